// File: doc/BRIEF.md
# SPI Slave Transfer Error Detector

This block holds the error-detection logic for an SPI slave. It watches the slave select line, a per-bit serial clock edge strobe, the transmit-empty indication and the receive FIFO fill level. It keeps four sticky status flags:

- a live transmit underrun flag;
- an end-of-transfer error flag, raised when select drops after an underrun;
- a receive overrun flag;
- a no-clock flag, raised when select pulsed with no serial clock in between.

Each flag is cleared by writing one to its bit. A single interrupt line combines the flags through three enable bits.

The receive side is a one-way word stream with no back-pressure. A completed word is offered on `rx_word_valid`. The block forwards it on `rx_push` while the FIFO has room. When the FIFO is full, the word is dropped and the overrun flag records the loss.

In three-wire mode, select is treated as permanently active. Underrun can then only be seen by polling the live flag, and the two end-of-transfer flags never set. The detector acts only while the controller is enabled and in slave mode.

Top module: `spi_slv_errdet`

## Requirements
- R1: After reset all four flags (bit 0 underrun, bit 1 end-of-transfer error, bit 2 overrun, bit 3 no-clock) read 0 and `irq` is 0.
- R2: A cycle with select active, `sclk_edge` high and `tx_empty` high sets flag bit 0 at the next clock edge.
- R3: A serial clock edge sets no underrun while `tx_empty` is low or select is inactive.
- R4: When `ss_n` rises after a transfer in which an underrun occurred, flag bit 1 sets at the next edge; a transfer without underrun leaves it clear.
- R5: When `ss_n` rises after a transfer with no `sclk_edge` at all, flag bit 3 sets at the next edge; a transfer that saw an edge leaves it clear.
- R6: `rx_full` is high exactly when `rx_level` equals RX_DEPTH (8). A word offered while full is not pushed (`rx_push` low) and sets flag bit 2; below full it is pushed and sets nothing.
- R7: With `three_wire` high, select counts as active regardless of `ss_n`, so underrun detection works with `ss_n` high; flag bits 1 and 3 never set.
- R8: While `en` or `slave_mode` is low, no flag sets and `rx_push` stays low.
- R9: A flag stays set until a one is written to its `flag_clr` bit. A clear in the same cycle as a set event leaves the flag set, and a clear touches only its own bit.
- R10: `irq` is high when any flag is set with its enable: `udr_ie` covers bits 0 and 1, `ovr_ie` covers bit 2, `nclk_ie` covers bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Controller enable |
| slave_mode | input | 1 | Controller in slave mode |
| three_wire | input | 1 | Treat select as always active |
| ss_n | input | 1 | Slave select, active low, synchronized |
| sclk_edge | input | 1 | One-cycle strobe per serial clock bit edge |
| tx_empty | input | 1 | Transmit buffer holds no data |
| rx_word_valid | input | 1 | A received word is complete |
| rx_level | input | 4 | Receive FIFO entries held |
| rx_push | output | 1 | Write the received word into the FIFO |
| rx_full | output | 1 | Receive FIFO holds RX_DEPTH entries |
| udr_ie | input | 1 | Enable for both underrun flags |
| ovr_ie | input | 1 | Enable for the overrun flag |
| nclk_ie | input | 1 | Enable for the no-clock flag |
| flag_clr | input | 4 | Write-one-to-clear, one bit per flag |
| flags | output | 4 | Sticky flags |
| irq | output | 1 | Interrupt request |

## Verification
Transfers are driven in four forms, and each one separates the flags:

- clocked with the transmit buffer empty, which should raise the underrun flag and, at select release, the end-of-transfer error;
- clocked with the buffer loaded, which should raise nothing;
- select pulsed with no clock, which should raise only the no-clock flag;
- three-wire traffic with `ss_n` idle high, which should raise underrun and never either end-of-transfer flag.

Receive words are offered at one entry below full and at full, which separates push from drop. Clears that coincide with a new event show whether set wins over clear. Toggling the enables against set flags checks how the interrupt is mapped.

// File: rtl/spi_errdet_pkg.sv
package spi_errdet_pkg;
  localparam int NFLAG    = 4;
  localparam int F_UDR    = 0;
  localparam int F_EOTERR = 1;
  localparam int F_OVR    = 2;
  localparam int F_NCLK   = 3;
endpackage

// File: rtl/spi_errdet_xfer.sv
// Tracks one select window and produces per-cycle error events.
module spi_errdet_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic live,        // enabled and in slave mode
  input  logic three_wire,
  input  logic ss_n,
  input  logic sclk_edge,
  input  logic tx_empty,
  output logic sel_active,
  output logic udr_evt,
  output logic eoterr_evt,
  output logic nclk_evt
);
  logic win_q, udr_seen_q, clk_seen_q, win_now, win_end;

  assign sel_active = live & (three_wire | ~ss_n);
  assign udr_evt    = sel_active & sclk_edge & tx_empty;
  // Windows are only tracked for four-wire operation.
  assign win_now    = live & ~three_wire & ~ss_n;
  assign win_end    = live & ~three_wire & win_q & ss_n;
  assign eoterr_evt = win_end & udr_seen_q;
  assign nclk_evt   = win_end & ~clk_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= 1'b0;
      udr_seen_q <= 1'b0;
      clk_seen_q <= 1'b0;
    end else begin
      win_q <= win_now;
      if (win_now) begin
        udr_seen_q <= udr_seen_q | udr_evt;
        clk_seen_q <= clk_seen_q | sclk_edge;
      end else begin
        udr_seen_q <= 1'b0;
        clk_seen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_errdet_flags.sv
// Sticky write-one-to-clear flag bank; set wins over clear.
module spi_errdet_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slv_errdet.sv
module spi_slv_errdet
  import spi_errdet_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  localparam int LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slave_mode,
  input  logic             three_wire,
  input  logic             ss_n,
  input  logic             sclk_edge,
  input  logic             tx_empty,
  input  logic             rx_word_valid,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_push,
  output logic             rx_full,
  input  logic             udr_ie,
  input  logic             ovr_ie,
  input  logic             nclk_ie,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic live, sel_active, udr_evt, eoterr_evt, nclk_evt, ovr_evt;
  logic [NFLAG-1:0] set_v, ie_v;

  assign live = en & slave_mode;

  spi_errdet_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .live(live), .three_wire(three_wire),
    .ss_n(ss_n), .sclk_edge(sclk_edge), .tx_empty(tx_empty),
    .sel_active(sel_active), .udr_evt(udr_evt),
    .eoterr_evt(eoterr_evt), .nclk_evt(nclk_evt)
  );

  assign rx_full = (rx_level == LVL_W'(RX_DEPTH));
  assign ovr_evt = sel_active & rx_word_valid & rx_full;
  assign rx_push = sel_active & rx_word_valid & ~rx_full;

  always_comb begin
    set_v           = '0;
    set_v[F_UDR]    = udr_evt;
    set_v[F_EOTERR] = eoterr_evt;
    set_v[F_OVR]    = ovr_evt;
    set_v[F_NCLK]   = nclk_evt;
    ie_v            = '0;
    ie_v[F_UDR]     = udr_ie;
    ie_v[F_EOTERR]  = udr_ie;
    ie_v[F_OVR]     = ovr_ie;
    ie_v[F_NCLK]    = nclk_ie;
  end

  spi_errdet_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(flag_clr), .q(flags)
  );

  assign irq = |(flags & ie_v);
endmodule

// File: rtl/spi_slv_errdet_chk.sv
module spi_slv_errdet_chk #(
  parameter int RX_DEPTH = 8,
  localparam int LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             slave_mode,
  input logic             three_wire,
  input logic             ss_n,
  input logic             sclk_edge,
  input logic             tx_empty,
  input logic             rx_word_valid,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_push,
  input logic [3:0]       flag_clr,
  input logic [3:0]       flags
);
  a_r2_udr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slave_mode && (three_wire || !ss_n) && sclk_edge && tx_empty) |=> flags[0]);

  a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_valid && rx_level == LVL_W'(RX_DEPTH)) |-> !rx_push);

  a_r7_no_eot_3w: assert property (@(posedge clk) disable iff (!rst_n)
    three_wire |=> (!$rose(flags[1]) && !$rose(flags[3])));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && slave_mode) |=> ((flags & ~$past(flags)) == 4'b0));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

bind spi_slv_errdet spi_slv_errdet_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode),
  .three_wire(three_wire), .ss_n(ss_n), .sclk_edge(sclk_edge),
  .tx_empty(tx_empty), .rx_word_valid(rx_word_valid), .rx_level(rx_level),
  .rx_push(rx_push), .flag_clr(flag_clr), .flags(flags)
);

// File: tb/spi_slv_errdet_tb_top.sv
module spi_slv_errdet_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, slave_mode = 0, three_wire = 0, ss_n = 1, sclk_edge = 0;
  logic tx_empty = 0, rx_word_valid = 0;
  logic [3:0] rx_level = 0;
  logic rx_push, rx_full, irq;
  logic udr_ie = 0, ovr_ie = 0, nclk_ie = 0;
  logic [3:0] flag_clr = 0;
  logic [3:0] flags;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_slv_errdet dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode),
    .three_wire(three_wire), .ss_n(ss_n), .sclk_edge(sclk_edge),
    .tx_empty(tx_empty), .rx_word_valid(rx_word_valid), .rx_level(rx_level),
    .rx_push(rx_push), .rx_full(rx_full), .udr_ie(udr_ie), .ovr_ie(ovr_ie),
    .nclk_ie(nclk_ie), .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; step(); flag_clr = 4'h0; step();
  endtask

  task automatic pulse_clk(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_edge = 1; step(); sclk_edge = 0; step();
    end
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 4'b0000);
    chk("R1 irq", {3'b0, irq}, 4'b0000);
  endtask

  task automatic t_underrun();
    en = 1; slave_mode = 1; three_wire = 0; tx_empty = 1;
    ss_n = 0; step();
    sclk_edge = 1; step(); sclk_edge = 0;
    chk("R2 udr set", flags, 4'b0001);
    step();
    ss_n = 1; step();
    chk("R4 eot error after udr", flags, 4'b0011);
    clear_all();
    chk("R9 cleared", flags, 4'b0000);
  endtask

  task automatic t_no_underrun();
    tx_empty = 0; ss_n = 0; step();
    pulse_clk(3);
    ss_n = 1; step();
    chk("R3/R4 loaded transfer clean", flags, 4'b0000);
    tx_empty = 1; pulse_clk(2);
    chk("R3 edge with select idle", flags, 4'b0000);
  endtask

  task automatic t_noclk();
    tx_empty = 1; ss_n = 0; step(3);
    ss_n = 1; step();
    chk("R5 no-clock flag", flags, 4'b1000);
    clear_all();
  endtask

  task automatic t_overrun();
    ss_n = 0; tx_empty = 0; step();
    rx_level = 4'd7; rx_word_valid = 1; #1;
    chk("R6 push below full", {2'b0, rx_push, rx_full}, 4'b0010);
    step(); rx_word_valid = 0;
    chk("R6 no overrun below full", flags, 4'b0000);
    rx_level = 4'd8; rx_word_valid = 1; #1;
    chk("R6 drop at full", {2'b0, rx_push, rx_full}, 4'b0001);
    step(); rx_word_valid = 0;
    chk("R6 overrun flag", flags, 4'b0100);
    pulse_clk(1);
    ss_n = 1; rx_level = 0; step();
    clear_all();
  endtask

  task automatic t_three_wire();
    three_wire = 1; ss_n = 1; tx_empty = 1; step();
    sclk_edge = 1; step(); sclk_edge = 0;
    chk("R7 udr with ss_n high", flags, 4'b0001);
    ss_n = 0; step(2); ss_n = 1; step(2);
    chk("R7 no end-of-transfer flags", flags, 4'b0001);
    three_wire = 0; clear_all();
  endtask

  task automatic t_disabled();
    en = 0; tx_empty = 1; ss_n = 0; step();
    pulse_clk(2);
    rx_level = 4'd8; rx_word_valid = 1; #1;
    chk("R8 no push when disabled", {3'b0, rx_push}, 4'b0000);
    step(); rx_word_valid = 0; rx_level = 0;
    ss_n = 1; step(2);
    chk("R8 disabled no flags", flags, 4'b0000);
    en = 1; slave_mode = 0; ss_n = 0; step(2); ss_n = 1; step(2);
    chk("R8 master mode no flags", flags, 4'b0000);
    slave_mode = 1;
  endtask

  task automatic t_w1c();
    tx_empty = 1; ss_n = 0; step();
    sclk_edge = 1; step();
    flag_clr = 4'b0001; step(); sclk_edge = 0; flag_clr = 0;
    chk("R9 set wins over clear", flags, 4'b0001);
    rx_level = 4'd8; rx_word_valid = 1; step(); rx_word_valid = 0; rx_level = 0;
    chk("R9 two flags set", flags, 4'b0101);
    flag_clr = 4'b0001; step(); flag_clr = 0; step();
    chk("R9 clear only own bit", flags, 4'b0100);
    tx_empty = 0; pulse_clk(1); ss_n = 1; step();
    clear_all();
  endtask

  task automatic t_irq();
    udr_ie = 0; ovr_ie = 0; nclk_ie = 0;
    tx_empty = 1; ss_n = 0; step(); pulse_clk(1);
    chk("R10 udr masked", {3'b0, irq}, 4'b0000);
    udr_ie = 1; #1;
    chk("R10 udr enabled", {3'b0, irq}, 4'b0001);
    ss_n = 1; step();
    flag_clr = 4'b0001; step(); flag_clr = 0; step();
    chk("R10 eot error alone via udr_ie", {irq, flags[2:0]}, 4'b1010);
    udr_ie = 0; #1;
    chk("R10 eot error masked", {3'b0, irq}, 4'b0000);
    clear_all();
    tx_empty = 0; ss_n = 0; step(2); ss_n = 1; step();
    ovr_ie = 1; #1;
    chk("R10 no-clock needs its own enable", {3'b0, irq}, 4'b0000);
    nclk_ie = 1; #1;
    chk("R10 no-clock enabled", {3'b0, irq}, 4'b0001);
    clear_all();
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1; step(2);
    t_reset();
    t_underrun();
    t_no_underrun();
    t_noclk();
    t_overrun();
    t_three_wire();
    t_disabled();
    t_w1c();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule